// File: doc/BRIEF.md
# Signed Widening Multiply by Selected Lane

This datapath multiplies each signed lane in one 64-bit half of a 128-bit first source vector by a single signed lane picked out of a 128-bit second source vector. It produces a 128-bit result whose lanes are twice as wide as the source lanes. It accepts the raw instruction fields directly: a 2-bit element-size code, a half selector, three index bits and a 4-bit partial register number. It decodes these fields into an element size, a scalar lane index and a 5-bit second-register number.

Reserved size codes produce no product. Instead they raise an undefined-instruction flag. Every result is registered exactly one cycle after a valid input is sampled, and an output valid strobe accompanies it. The path has a fixed depth, so its timing never depends on the operand values. Register-file access and trap handling belong to the surrounding pipeline.

Top module: `widen_mul_lane`

## Requirements
- R1: With `fld_size`=01 the source lanes are 16 bits wide. The four products are 32 bits each, and product e occupies `result[32e+31:32e]`.
- R2: With `fld_size`=10 the source lanes are 32 bits wide. The two products are 64 bits each, and product e occupies `result[64e+63:64e]`.
- R3: `fld_size`=00 or 11 sets `undef`=1 and forces `result` and `breg_num` to zero. Codes 01 and 10 give `undef`=0.
- R4: With `half_sel`=0 the first-operand lanes come from `src_a[63:0]`. With `half_sel`=1 they come from `src_a[127:64]`. In both cases lane e starts at the lowest bit of the chosen half plus e times the lane width.
- R5: For 16-bit lanes the scalar index is {`ix_hi`,`ix_mid`,`ix_lo`}, which selects `src_b[16k+15:16k]`. The register number is {0,`rsel_lo`}.
- R6: For 32-bit lanes the scalar index is {`ix_hi`,`ix_mid`}, which selects `src_b[32k+31:32k]`. The register number is {`ix_lo`,`rsel_lo`}.
- R7: Each product is the exact two's-complement product of two signed lanes. For example, -32768 times -32768 gives 0x40000000, and -2^31 times -2^31 gives 0x4000000000000000.
- R8: The outputs reflect an input sampled with `in_valid`=1 at the next rising edge. `out_valid` is high for exactly that cycle, whatever the data.
- R9: A cycle with `in_valid`=0 leaves `result`, `breg_num` and `undef` unchanged and drives `out_valid` low at the next edge.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input fields and vectors are valid |
| fld_size | input | 2 | Element size code |
| half_sel | input | 1 | Selects the upper half of `src_a` when 1 |
| ix_hi | input | 1 | Index bit, most significant |
| ix_mid | input | 1 | Index bit, middle |
| ix_lo | input | 1 | Index bit for 16-bit lanes, or register-number top bit for 32-bit lanes |
| rsel_lo | input | 4 | Low bits of the second register number |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 128 | Widened products |
| breg_num | output | 5 | Decoded second register number |
| undef | output | 1 | Reserved size code seen |

## Verification
The assertions assume that the reset is released synchronously with respect to the sampled fields. They also assume that `in_valid` and all field inputs are free of unknowns once the reset has been released. The bench drives every input at the falling clock edge from fully specified constants, so no X ever reaches a sampled edge. It also keeps `in_valid` low whenever it is not deliberately issuing an operation, so the hold property sees only real idle cycles.

// File: rtl/wml_pkg.sv
package wml_pkg;
   typedef enum logic [1:0] {
      MODE_NARROW = 2'd0,
      MODE_WIDE   = 2'd1,
      MODE_BAD    = 2'd2
   } wml_mode_e;

   localparam int unsigned IDX_W = 3;
   localparam int unsigned RSEL_W = 4;
   localparam int unsigned BREG_W = RSEL_W + 1;
endpackage

// File: rtl/wml_decode.sv
module wml_decode
   import wml_pkg::*;
(
   input  logic [1:0]        fld_size,
   input  logic              ix_hi,
   input  logic              ix_mid,
   input  logic              ix_lo,
   input  logic [RSEL_W-1:0] rsel_lo,
   output wml_mode_e         mode,
   output logic [IDX_W-1:0]  lane_idx,
   output logic [BREG_W-1:0] breg,
   output logic              bad
);
   always_comb begin
      mode     = MODE_BAD;
      lane_idx = '0;
      breg     = '0;
      bad      = 1'b1;
      unique case (fld_size)
         2'b01: begin
            mode     = MODE_NARROW;
            lane_idx = {ix_hi, ix_mid, ix_lo};
            breg     = {1'b0, rsel_lo};
            bad      = 1'b0;
         end
         2'b10: begin
            mode     = MODE_WIDE;
            lane_idx = {1'b0, ix_hi, ix_mid};
            breg     = {ix_lo, rsel_lo};
            bad      = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/wml_lane_pick.sv
module wml_lane_pick
   import wml_pkg::*;
#(
   parameter int unsigned VEC_W    = 128,
   parameter int unsigned NARROW_W = 16
) (
   input  logic [VEC_W-1:0]      src_b,
   input  logic [IDX_W-1:0]      lane_idx,
   output logic [NARROW_W-1:0]   scalar_n,
   output logic [2*NARROW_W-1:0] scalar_w
);
   localparam int unsigned WIDE_W = 2 * NARROW_W;
   localparam int unsigned N_NAR  = VEC_W / NARROW_W;
   localparam int unsigned N_WID  = VEC_W / WIDE_W;

   logic [NARROW_W-1:0] nar_lane [N_NAR];
   logic [WIDE_W-1:0]   wid_lane [N_WID];

   for (genvar k = 0; k < N_NAR; k++) begin : g_nar
      assign nar_lane[k] = src_b[k*NARROW_W +: NARROW_W];
   end
   for (genvar k = 0; k < N_WID; k++) begin : g_wid
      assign wid_lane[k] = src_b[k*WIDE_W +: WIDE_W];
   end

   assign scalar_n = nar_lane[lane_idx];
   assign scalar_w = wid_lane[lane_idx[IDX_W-2:0]];
endmodule

// File: rtl/wml_mul_array.sv
module wml_mul_array #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned LANE_W = 16
) (
   input  logic [HALF_W-1:0]   half_op,
   input  logic [LANE_W-1:0]   scalar,
   output logic [2*HALF_W-1:0] prod
);
   localparam int unsigned N_LANE = HALF_W / LANE_W;
   localparam int unsigned PROD_W = 2 * LANE_W;

   for (genvar e = 0; e < N_LANE; e++) begin : g_lane
      logic signed [LANE_W-1:0] lhs;
      logic signed [LANE_W-1:0] rhs;
      logic signed [PROD_W-1:0] p;
      assign lhs = half_op[e*LANE_W +: LANE_W];
      assign rhs = scalar;
      assign p   = PROD_W'(lhs) * PROD_W'(rhs);
      assign prod[e*PROD_W +: PROD_W] = p;
   end
endmodule

// File: rtl/widen_mul_lane.sv
module widen_mul_lane
   import wml_pkg::*;
#(
   parameter int unsigned VEC_W    = 128,
   parameter int unsigned NARROW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        fld_size,
   input  logic              half_sel,
   input  logic              ix_hi,
   input  logic              ix_mid,
   input  logic              ix_lo,
   input  logic [3:0]        rsel_lo,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result,
   output logic [4:0]        breg_num,
   output logic              undef
);
   localparam int unsigned HALF_W = VEC_W / 2;
   localparam int unsigned WIDE_W = 2 * NARROW_W;

   if (VEC_W / NARROW_W != (1 << IDX_W)) begin : g_bad_ratio
      $error("VEC_W must hold exactly 2**IDX_W narrow lanes");
   end
   if (VEC_W % WIDE_W != 0) begin : g_bad_width
      $error("VEC_W must be a multiple of the wide lane width");
   end

   wml_mode_e           mode;
   logic [IDX_W-1:0]    lane_idx;
   logic [BREG_W-1:0]   breg_d;
   logic                bad_d;
   logic [HALF_W-1:0]   half_op;
   logic [NARROW_W-1:0] scalar_n;
   logic [WIDE_W-1:0]   scalar_w;
   logic [VEC_W-1:0]    prod_n;
   logic [VEC_W-1:0]    prod_w;
   logic [VEC_W-1:0]    res_d;

   wml_decode u_dec (
      .fld_size (fld_size),
      .ix_hi    (ix_hi),
      .ix_mid   (ix_mid),
      .ix_lo    (ix_lo),
      .rsel_lo  (rsel_lo),
      .mode     (mode),
      .lane_idx (lane_idx),
      .breg     (breg_d),
      .bad      (bad_d)
   );

   wml_lane_pick #(.VEC_W(VEC_W), .NARROW_W(NARROW_W)) u_pick (
      .src_b    (src_b),
      .lane_idx (lane_idx),
      .scalar_n (scalar_n),
      .scalar_w (scalar_w)
   );

   assign half_op = half_sel ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];

   wml_mul_array #(.HALF_W(HALF_W), .LANE_W(NARROW_W)) u_mul_n (
      .half_op (half_op),
      .scalar  (scalar_n),
      .prod    (prod_n)
   );

   wml_mul_array #(.HALF_W(HALF_W), .LANE_W(WIDE_W)) u_mul_w (
      .half_op (half_op),
      .scalar  (scalar_w),
      .prod    (prod_w)
   );

   always_comb begin
      unique case (mode)
         MODE_NARROW: res_d = prod_n;
         MODE_WIDE:   res_d = prod_w;
         default:     res_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         breg_num  <= '0;
         undef     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= res_d;
            breg_num <= breg_d;
            undef    <= bad_d;
         end
      end
   end
endmodule

// File: rtl/wml_checker.sv
module wml_checker #(
   parameter int unsigned VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       fld_size,
   input logic             ix_lo,
   input logic [3:0]       rsel_lo,
   input logic             out_valid,
   input logic [VEC_W-1:0] result,
   input logic [4:0]       breg_num,
   input logic             undef
);
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(breg_num) && $stable(undef))); // R9
   AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (undef == ($past(fld_size) == 2'b00 || $past(fld_size) == 2'b11))); // R3
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && undef) |-> (result == '0 && breg_num == '0)); // R3
   AST_NARROW_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fld_size == 2'b01) |=> (breg_num == {1'b0, $past(rsel_lo)})); // R5
   AST_WIDE_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fld_size == 2'b10) |=> (breg_num == {$past(ix_lo), $past(rsel_lo)})); // R6
endmodule

bind widen_mul_lane wml_checker #(.VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .fld_size  (fld_size),
   .ix_lo     (ix_lo),
   .rsel_lo   (rsel_lo),
   .out_valid (out_valid),
   .result    (result),
   .breg_num  (breg_num),
   .undef     (undef)
);

// File: tb/widen_mul_lane_test.sv
module widen_mul_lane_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0]   sz;
      logic         q;
      logic         h;
      logic         l;
      logic         m;
      logic [3:0]   rs;
      logic [127:0] a;
      logic [127:0] b;
   } stim_t;

   localparam int NTBL = 8;
   localparam stim_t TBL [NTBL] = '{
      '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'h3, 128'h0000_0000_0000_0000_0004_0003_0002_0001, 128'h0000_0000_0000_0000_0000_0000_0000_0005},
      '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 128'hFFFF_8000_7FFF_0001_1111_2222_3333_4444, 128'h0000_FFFE_0000_0000_0000_0000_0000_0000},
      '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 4'h9, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h1111_2222_3333_4444_5555_6666_7777_8888},
      '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 4'h7, 128'h0000_0000_0000_0000_FFFF_FFFF_0000_0002, 128'h0000_0000_0000_0000_0000_0003_0000_0000},
      '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 128'h7FFF_FFFF_8000_0000_0000_0000_0000_0000, 128'h8000_0000_0000_0000_0000_0000_0000_0000},
      '{2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'h1, 128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0, 128'h0000_0000_FFFF_FFF9_0000_0000_0000_0000},
      '{2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 4'h5, 128'h1234_1234_1234_1234_1234_1234_1234_1234, 128'h0001_0001_0001_0001_0001_0001_0001_0001},
      '{2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 4'hC, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   fld_size = 2'b00;
   logic         half_sel = 1'b0;
   logic         ix_hi = 1'b0;
   logic         ix_mid = 1'b0;
   logic         ix_lo = 1'b0;
   logic [3:0]   rsel_lo = 4'h0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_valid;
   logic [127:0] result;
   logic [4:0]   breg_num;
   logic         undef;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   widen_mul_lane uut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .fld_size (fld_size),
      .half_sel (half_sel), .ix_hi (ix_hi), .ix_mid (ix_mid), .ix_lo (ix_lo),
      .rsel_lo (rsel_lo), .src_a (src_a), .src_b (src_b), .out_valid (out_valid),
      .result (result), .breg_num (breg_num), .undef (undef)
   );

   function automatic logic [127:0] model_res(stim_t s);
      logic [127:0] r = '0;
      logic [63:0] hv = s.q ? s.a[127:64] : s.a[63:0];
      if (s.sz == 2'b01) begin
         int k = {s.h, s.l, s.m};
         logic signed [15:0] sc = s.b[k*16 +: 16];
         for (int e = 0; e < 4; e++) begin
            logic signed [15:0] x = hv[e*16 +: 16];
            logic signed [31:0] p = 32'(x) * 32'(sc);
            r[e*32 +: 32] = p;
         end
      end else if (s.sz == 2'b10) begin
         int k = {s.h, s.l};
         logic signed [31:0] sc = s.b[k*32 +: 32];
         for (int e = 0; e < 2; e++) begin
            logic signed [31:0] x = hv[e*32 +: 32];
            logic signed [63:0] p = 64'(x) * 64'(sc);
            r[e*64 +: 64] = p;
         end
      end
      return r;
   endfunction

   function automatic logic [4:0] model_reg(stim_t s);
      if (s.sz == 2'b01) return {1'b0, s.rs};
      if (s.sz == 2'b10) return {s.m, s.rs};
      return 5'd0;
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(stim_t s);
      @(negedge clk);
      fld_size = s.sz; half_sel = s.q; ix_hi = s.h; ix_mid = s.l; ix_lo = s.m;
      rsel_lo = s.rs; src_a = s.a; src_b = s.b; in_valid = 1'b1;
   endtask

   task automatic verify(string req, stim_t s);
      chk({req, " out_valid"}, 128'(out_valid), 128'd1);
      chk({req, " result"}, result, model_res(s));
      chk({req, " breg_num"}, 128'(breg_num), 128'(model_reg(s)));
      chk({req, " undef"}, 128'(undef), 128'(s.sz == 2'b00 || s.sz == 2'b11));
   endtask

   task automatic run_one(string req, stim_t s);
      drive(s);
      @(negedge clk);
      in_valid = 1'b0;
      verify(req, s);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      stim_t s;
      logic [127:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 out_valid", 128'(out_valid), 128'd0);
      chk("R10 result", result, 128'd0);
      chk("R10 breg_num", 128'(breg_num), 128'd0);
      chk("R10 undef", 128'(undef), 128'd0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 table walk
      for (int i = 0; i < NTBL; i++) run_one("R1/R2/R3/R4 table", TBL[i]);

      // R5 every narrow index, both halves
      for (int q = 0; q < 2; q++) begin
         for (int k = 0; k < 8; k++) begin
            s = '{2'b01, q[0], k[2], k[1], k[0], 4'(k + 3),
                  128'hF00D_8001_7FFE_0100_FFFF_0002_8000_7FFF,
                  128'h8000_7FFF_0003_FFFD_0100_FF00_0007_C000};
            run_one("R5 narrow index", s);
         end
      end
      // R6 every wide index, both halves
      for (int q = 0; q < 2; q++) begin
         for (int k = 0; k < 4; k++) begin
            s = '{2'b10, q[0], k[1], k[0], k[0] ^ q[0], 4'(k * 3),
                  128'h8000_0000_7FFF_FFFF_FFFF_FFFE_0001_0000,
                  128'h8000_0000_0000_0007_FFFF_FFF0_7FFF_FFFF};
            run_one("R6 wide index", s);
         end
      end

      // R7 extremes, hand expectations
      s = '{2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 4'h2, {64'h8000_8000_8000_8000, 64'h0}, {16'h8000, 112'h0}};
      drive(s); @(negedge clk); in_valid = 1'b0;
      chk("R7 min16*min16", result, {4{32'h4000_0000}});
      s = '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 4'h2, {64'h0, 64'h8000_0000_8000_0000}, {96'h0, 32'h8000_0000}};
      drive(s); @(negedge clk); in_valid = 1'b0;
      chk("R7 min32*min32", result, {2{64'h4000_0000_0000_0000}});
      s = '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, {64'h0, 64'h7FFF_8000_FFFF_0001}, {112'h0, 16'hFFFF}};
      drive(s); @(negedge clk); in_valid = 1'b0;
      chk("R7 by minus one", result, {32'hFFFF_8001, 32'h0000_8000, 32'h0000_0001, 32'hFFFF_FFFF});

      // R9 hold while idle
      held = result;
      src_a = ~src_a; src_b = ~src_b; fld_size = 2'b11;
      @(negedge clk);
      chk("R9 out_valid low", 128'(out_valid), 128'd0);
      chk("R9 result held", result, held);
      chk("R9 undef held", 128'(undef), 128'd0);

      // R8 back-to-back issues, one cycle each
      drive(TBL[1]);
      drive(TBL[4]);
      verify("R8 first", TBL[1]);
      @(negedge clk);
      in_valid = 1'b0;
      verify("R8 second", TBL[4]);
      @(negedge clk);
      chk("R8 single pulse", 128'(out_valid), 128'd0);

      // R3 reserved after a good result clears it
      run_one("R3 reserved 11", TBL[7]);
      run_one("R3 reserved 00", TBL[6]);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule